// File: doc/BRIEF.md
# Keyboard Input Register Port

This block sits on a 16-bit processor memory bus and presents a keyboard-side device as two word-addressed registers: a status word and a character word. An upstream keyboard scanner presents a byte-wide character together with a one-cycle strobe. The port latches that character, raises a ready flag, and then refuses any further characters until software has read the character word. Software polls the status word, or enables an interrupt, to learn that a character is waiting.

The status word also holds an interrupt-enable bit that software can write. The port raises an interrupt request whenever a character is waiting and interrupts are enabled. Address decoding for the two registers and the read-data multiplexing are part of the block. Interrupt arbitration belongs to the processor side and is not part of the block.

Top module: `kbd_input_port`

## Requirements
- R1: Synchronous active-high reset clears the ready flag, the interrupt-enable bit and the held character. After reset both registers read as 0x0000 and the interrupt request is low.
- R2: A strobe with ready at 0 and no character-word read latches the character. From the next cycle on, the status word (address 0xFE00) reads bit 15 as 1 and the character word (address 0xFE02) returns the character.
- R3: A strobe that arrives while ready is 1 is dropped, and the held character is kept.
- R4: A bus read of address 0xFE02 clears ready starting in the next cycle and makes capture possible again.
- R5: A character-word read and a strobe in the same cycle clear ready and drop the new character.
- R6: A bus write to 0xFE00 stores data bit 14 as interrupt enable and leaves ready unchanged. Status bits 13..0 always read as zero.
- R7: The interrupt request is high exactly while ready and interrupt enable are both 1, and it follows them in the same cycle.
- R8: Read data is 0x0000 when busRead is low or the address matches neither register. Writes to any address other than 0xFE00, including 0xFE02, change no state.
- R9: Bits 15..8 of the character word always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 16 | Word address of the bus access |
| busRead | input | 1 | Read access this cycle |
| busWrite | input | 1 | Write access this cycle |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data |
| keyChar | input | 8 | Character from the keyboard scanner |
| keyStrobe | input | 1 | One-cycle strobe marking keyChar as new |
| irqReq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so each access is checked in the cycle it is presented, against a model that holds the register state from before the clock edge. State changes caused by a strobe, a character-word read or a status write become visible from the following cycle. The bench therefore updates its model only after that edge and compares the next access against it. The interrupt request follows the flags with no added register, so it is compared in every cycle against the model's ready and enable bits.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  // strobes from the control section to the datapath
  typedef struct packed {
    logic captureEn;  // latch keyChar into the held character
    logic readyClr;   // character word is being read
    logic ieWrEn;     // status word is being written
    logic ieWrVal;    // value of the enable bit on that write
  } kbdStrobeT;
endpackage

// File: rtl/kbd_port_ctrl.sv
module kbd_port_ctrl
  import kbd_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] CHAR_ADDR = 16'hFE02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              wrIeBit,
  input  logic              keyStrobe,
  output kbdStrobeT         strb,
  output logic              statusSel,
  output logic              charSel,
  output logic              readyFlag,
  output logic              ieFlag,
  output logic              irqReq
);

  logic charRd;
  logic statWr;

  always_comb begin
    statusSel = (busAddr == STAT_ADDR);
    charSel   = (busAddr == CHAR_ADDR);
    charRd    = busRead && charSel;
    statWr    = busWrite && statusSel;
    strb.readyClr  = charRd;
    // a read in the same cycle wins over a new character
    strb.captureEn = keyStrobe && !readyFlag && !charRd;
    strb.ieWrEn    = statWr;
    strb.ieWrVal   = wrIeBit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      readyFlag <= 1'b0;
    end else if (strb.readyClr) begin
      readyFlag <= 1'b0;
    end else if (strb.captureEn) begin
      readyFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ieFlag <= 1'b0;
    end else if (strb.ieWrEn) begin
      ieFlag <= strb.ieWrVal;
    end
  end

  assign irqReq = readyFlag && ieFlag;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !readyFlag && !ieFlag); // R1
  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (rst)
    (keyStrobe && !charRd) |=> readyFlag); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    charRd |=> !readyFlag); // R4
  AST_SW_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (!keyStrobe && !charRd) |=> $stable(readyFlag)); // R6
  AST_IE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !statWr |=> $stable(ieFlag)); // R8

endmodule

// File: rtl/kbd_port_dp.sv
module kbd_port_dp
  import kbd_port_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int READY_BIT = 15,
  parameter int IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  kbdStrobeT         strb,
  input  logic [CHAR_W-1:0] keyChar,
  input  logic              busRead,
  input  logic              statusSel,
  input  logic              charSel,
  input  logic              readyFlag,
  input  logic              ieFlag,
  output logic [CHAR_W-1:0] charHeld,
  output logic [DATA_W-1:0] busRdata
);

  localparam int PAD_W = DATA_W - CHAR_W;

  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] charWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      charHeld <= '0;
    end else if (strb.captureEn) begin
      charHeld <= keyChar;
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[READY_BIT] = readyFlag;
    statusWord[IE_BIT]    = ieFlag;
    charWord              = {{PAD_W{1'b0}}, charHeld};
    if (!busRead) begin
      busRdata = '0;
    end else if (statusSel) begin
      busRdata = statusWord;
    end else if (charSel) begin
      busRdata = charWord;
    end else begin
      busRdata = '0;
    end
  end

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (readyFlag || strb.readyClr) |=> $stable(charHeld)); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busRead && charSel) |-> (busRdata[DATA_W-1:CHAR_W] == '0)); // R9

endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] CHAR_ADDR = 16'hFE02,
  parameter int READY_BIT = 15,
  parameter int IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CHAR_W-1:0] keyChar,
  input  logic              keyStrobe,
  output logic              irqReq
);

  localparam logic [DATA_W-1:0] IE_MASK = DATA_W'(1) << IE_BIT;

  kbdStrobeT         strb;
  logic              statusSel;
  logic              charSel;
  logic              readyFlag;
  logic              ieFlag;
  logic [CHAR_W-1:0] charHeld;
  logic              unusedWdata;

  assign unusedWdata = ^(busWdata & ~IE_MASK);

  kbd_port_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CHAR_ADDR(CHAR_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .wrIeBit(busWdata[IE_BIT]), .keyStrobe(keyStrobe),
    .strb(strb), .statusSel(statusSel), .charSel(charSel),
    .readyFlag(readyFlag), .ieFlag(ieFlag), .irqReq(irqReq)
  );

  kbd_port_dp #(
    .DATA_W(DATA_W), .CHAR_W(CHAR_W), .READY_BIT(READY_BIT), .IE_BIT(IE_BIT)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .keyChar(keyChar), .busRead(busRead),
    .statusSel(statusSel), .charSel(charSel), .readyFlag(readyFlag),
    .ieFlag(ieFlag), .charHeld(charHeld), .busRdata(busRdata)
  );

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irqReq) |-> ($past(keyStrobe) || $past(busWrite))); // R7
  AST_IRQ_DROP_READ: assert property (@(posedge clk) disable iff (rst)
    (busRead && busAddr == CHAR_ADDR) |=> !irqReq); // R7

endmodule

// File: tb/kbd_input_port_tb.sv
module kbd_input_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] STAT_A = 16'hFE00;
  localparam logic [15:0] CHAR_A = 16'hFE02;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] busAddr;
  logic        busRead;
  logic        busWrite;
  logic [15:0] busWdata;
  logic [15:0] busRdata;
  logic [7:0]  keyChar;
  logic        keyStrobe;
  logic        irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  bit mReady = 0;
  bit mIe = 0;
  logic [7:0] mChar = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_input_port u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .keyChar(keyChar), .keyStrobe(keyStrobe), .irqReq(irqReq)
  );

  function automatic logic [15:0] expRead(logic [15:0] a, logic rd);
    if (!rd) return 16'h0000;
    if (a == STAT_A) return {mReady, mIe, 14'b0};
    if (a == CHAR_A) return {8'h00, mChar};
    return 16'h0000;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic [15:0] a, logic rd, logic wr, logic [15:0] wd,
                      logic stb, logic [7:0] ch, string tag);
    bit charRd;
    @(negedge clk);
    busAddr = a; busRead = rd; busWrite = wr; busWdata = wd;
    keyStrobe = stb; keyChar = ch;
    #1;
    check(tag, busRdata, expRead(a, rd));
    check("R7", {15'b0, irqReq}, {15'b0, mReady && mIe});
    @(posedge clk);
    charRd = rd && (a == CHAR_A);
    if (rst) begin
      mReady = 0; mIe = 0; mChar = '0;
    end else begin
      if (stb && !mReady && !charRd) mChar = ch;
      if (charRd) mReady = 0;
      else if (stb) mReady = 1;
      if (wr && a == STAT_A) mIe = wd[14];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd2016));
    rst = 1; busAddr = '0; busRead = 0; busWrite = 0; busWdata = '0;
    keyChar = '0; keyStrobe = 0;
    step(16'h0, 0, 0, 0, 0, 0, "R1");
    step(STAT_A, 1, 0, 0, 0, 0, "R1");
    step(CHAR_A, 1, 0, 0, 0, 0, "R1");
    rst = 0;
    step(STAT_A, 1, 0, 0, 0, 0, "R1");
    step(CHAR_A, 1, 0, 0, 0, 0, "R1");
    // capture, then blocked strobe
    step(16'h0, 1, 0, 0, 1, 8'h41, "R8");
    step(STAT_A, 1, 0, 0, 0, 0, "R2");
    step(16'h0, 0, 0, 0, 1, 8'h42, "R3");
    step(CHAR_A, 1, 0, 0, 0, 0, "R3");
    step(STAT_A, 1, 0, 0, 0, 0, "R4");
    step(16'h0, 0, 0, 0, 1, 8'h43, "R4");
    // read and strobe together
    step(CHAR_A, 1, 0, 0, 1, 8'h44, "R5");
    step(CHAR_A, 1, 0, 0, 0, 0, "R5");
    step(STAT_A, 1, 0, 0, 0, 0, "R5");
    // status write touches only the enable bit
    step(STAT_A, 0, 1, 16'hFFFF, 0, 0, "R6");
    step(STAT_A, 1, 0, 0, 0, 0, "R6");
    step(16'h0, 0, 0, 0, 1, 8'h5A, "R7");
    step(STAT_A, 1, 0, 0, 0, 0, "R7");
    step(STAT_A, 0, 1, 16'h0000, 0, 0, "R6");
    step(STAT_A, 1, 0, 0, 0, 0, "R6");
    step(STAT_A, 0, 1, 16'h4000, 0, 0, "R6");
    // writes elsewhere change nothing
    step(CHAR_A, 0, 1, 16'hFFFF, 0, 0, "R8");
    step(CHAR_A, 1, 0, 0, 0, 0, "R9");
    step(16'hFE01, 1, 1, 16'h0000, 0, 0, "R8");
    step(STAT_A, 1, 0, 0, 0, 0, "R8");
    step(CHAR_A, 0, 0, 0, 0, 0, "R8");
    step(16'hFE04, 1, 0, 0, 1, 8'hFF, "R8");
    step(CHAR_A, 1, 0, 0, 0, 0, "R9");
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [1:0] sel;
      string tag;
      sel = 2'($urandom_range(0, 3));
      a = (sel == 0) ? 16'($urandom) : (sel[0] ? STAT_A : CHAR_A);
      tag = (a == STAT_A) ? "R6" : (a == CHAR_A) ? "R2" : "R8";
      step(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
           16'($urandom), 1'($urandom_range(0, 2) == 0), 8'($urandom), tag);
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule